// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides what happens to each received CAN frame, using only the frame's identifier. Two small local lists hold the filter elements: one for 11-bit standard identifiers and one for 29-bit extended identifiers. When a frame arrives, the block walks the list that fits the frame's format, one element word per clock, starting at index 0. It stops at the first enabled element that hits. It then returns one of five verdicts: receive FIFO 0, receive FIFO 1, dedicated buffer, debug message, or reject. With the verdict it returns the index of the deciding element, a priority indication, the buffer index or debug kind, and a flag for frames that were accepted without any hit.

Each element selects its own comparison: an inclusive range, a pair of exact values, or a value with a bit mask. Each element also carries a 3-bit action code. Extended identifiers are ANDed with a global mask before they are compared. One extended range type compares the unmasked identifier. Global settings can reject remote frames, and can reject frames that hit no element. Each of these settings exists separately for the standard list and the extended list.

Filter elements are written through a simple word write port. The lengths of the active lists come from the count inputs.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `res_done`, `res_verdict`, `res_index`, `res_nomatch`, `res_prio`, `res_prio_index`, `res_buf_index` and `res_dbg_kind` are all 0.
- R2: A standard element is one word, and only the low 11 bits of `frm_id` are compared against it. Its fields are: match type in bits 31:30, action code in 29:27, first ID in 26:16 and second ID in 10:0. Match type 0 hits when first ID <= id <= second ID, with both bounds inclusive.
- R3: Match type 1 hits when the identifier equals either the first ID or the second ID.
- R4: Match type 2 hits when the identifier and the first ID agree on every bit that is set in the second ID.
- R5: Verdict codes are: 0 reject, 1 FIFO 0, 2 FIFO 1, 3 dedicated buffer, 4 debug. Action code 1 gives FIFO 0, code 2 gives FIFO 1 and code 3 gives reject. Each of these ends the scan, and `res_index` reports the element index.
- R6: Elements are examined in ascending index order and the first hit decides. An element with action code 0 never hits.
- R7: Action code 4 records its index as the priority element (`res_prio`=1, `res_prio_index`) and the scan continues. Codes 5 and 6 do the same and then end the scan with FIFO 0 or FIFO 1 respectively.
- R8: Action code 7 hits only on an exact match with the first ID, whatever the match type. In the second-ID field, bits 10:9 select the result: 0 gives the dedicated-buffer verdict with `res_buf_index` taken from bits 5:0, and 1, 2 or 3 give the debug verdict with `res_dbg_kind` equal to that value. `res_buf_index` and `res_dbg_kind` are 0 for every other verdict.
- R9: An extended element is two words, written at word addresses 2i and 2i+1. Word 0 holds the action code in bits 31:29 and the first ID in 28:0. Word 1 holds the match type in bits 31:30 and the second ID in 28:0. For match types 0 to 2 and for code 7, the identifier is ANDed with `ext_id_mask` before comparison.
- R10: Extended match type 3 is an inclusive range that compares the identifier without applying `ext_id_mask`.
- R11: A remote frame is rejected without a scan when the remote-reject setting for its format is 1. The index reported is then 0. When that setting is 0, a remote frame is filtered like any other frame.
- R12: A frame that hits no element is rejected when the no-match reject setting for its format is 1. Otherwise it goes to FIFO 0 with `res_nomatch`=1. `res_nomatch` is 0 in every other case.
- R13: `frm_valid` is sampled at a clock edge. `res_done` is high for one cycle, starting L edges after that edge. L is the number of element words read: i+1 for a decision at standard element i, 2(i+1) at extended element i, the full active list length in words when nothing hits, and 0 for a remote reject or an empty list.
- R14: Only elements with index below the count for that format (`std_count` or `ext_count`) are examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_we | input | 1 | Filter word write strobe |
| flt_we_ext | input | 1 | Write targets the extended list (1) or the standard list (0) |
| flt_waddr | input | AW (4) | Word address within the selected list |
| flt_wdata | input | 32 | Filter word to write |
| std_count | input | 5 | Number of active standard elements |
| ext_count | input | 4 | Number of active extended elements |
| std_rtr_reject | input | 1 | Reject remote standard frames |
| ext_rtr_reject | input | 1 | Reject remote extended frames |
| std_nomatch_reject | input | 1 | Reject standard frames that hit no element |
| ext_nomatch_reject | input | 1 | Reject extended frames that hit no element |
| ext_id_mask | input | 29 | Global AND mask applied to extended identifiers |
| frm_valid | input | 1 | A frame identifier is presented (only taken while idle) |
| frm_id | input | 29 | Frame identifier (standard frames use bits 10:0) |
| frm_ext | input | 1 | Frame carries an extended identifier |
| frm_rtr | input | 1 | Frame is a remote frame |
| res_done | output | 1 | One-cycle strobe: result outputs are valid |
| res_verdict | output | 3 | Verdict code (see R5) |
| res_index | output | 7 | Index of the deciding element |
| res_nomatch | output | 1 | Frame was accepted without any hit |
| res_prio | output | 1 | A priority element was hit |
| res_prio_index | output | 7 | Index of the latest priority element hit |
| res_buf_index | output | 6 | Dedicated buffer index |
| res_dbg_kind | output | 2 | Debug message kind (1 to 3) |

## Verification
A wrong scan pointer or a wrong word phase shows up in two ways at the ports: `res_index` reports the wrong element, and the done strobe arrives at the wrong edge. The bench therefore checks the exact cycle of every strobe, counting from its own frame launch. Priority state left over from an earlier frame, or a mask applied to the wrong comparison, changes the fields reported with the very next result. Frames are chosen so that each list contains overlapping elements, disabled elements that would otherwise hit, and identifiers just outside each bound. As a result, a decision taken one element too early or too late changes both the index and the latency.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    typedef enum logic [2:0] {
        V_REJECT = 3'd0,
        V_FIFO0  = 3'd1,
        V_FIFO1  = 3'd2,
        V_DBUF   = 3'd3,
        V_DEBUG  = 3'd4
    } verdict_e;

    localparam logic [2:0] C_OFF     = 3'd0;
    localparam logic [2:0] C_FIFO0   = 3'd1;
    localparam logic [2:0] C_FIFO1   = 3'd2;
    localparam logic [2:0] C_REJ     = 3'd3;
    localparam logic [2:0] C_PRIO    = 3'd4;
    localparam logic [2:0] C_PRIO0   = 3'd5;
    localparam logic [2:0] C_PRIO1   = 3'd6;
    localparam logic [2:0] C_SPECIAL = 3'd7;

    localparam int IDX_W = 7;

    typedef struct packed {
        logic       hit;
        logic [2:0] code;
        logic [5:0] buf_idx;
        logic [1:0] dbg_sel;
    } elem_res_t;

    // standard comparison; code 7 reuses the second ID field, so exact ID1 only
    function automatic logic std_match(input logic [1:0] typ, input logic [2:0] code,
                                       input logic [10:0] sid, input logic [10:0] id1,
                                       input logic [10:0] id2);
        if (code == C_SPECIAL) return sid == id1;
        case (typ)
            2'd0:    return (sid >= id1) && (sid <= id2);
            2'd1:    return (sid == id1) || (sid == id2);
            2'd2:    return ((sid ^ id1) & id2) == 11'd0;
            default: return 1'b0;
        endcase
    endfunction

    // extended comparison; type 3 range uses the unmasked identifier
    function automatic logic ext_match(input logic [1:0] typ, input logic [2:0] code,
                                       input logic [28:0] raw, input logic [28:0] msk,
                                       input logic [28:0] id1, input logic [28:0] id2);
        if (code == C_SPECIAL) return msk == id1;
        case (typ)
            2'd0:    return (msk >= id1) && (msk <= id2);
            2'd1:    return (msk == id1) || (msk == id2);
            2'd2:    return ((msk ^ id1) & id2) == 29'd0;
            default: return (raw >= id1) && (raw <= id2);
        endcase
    endfunction

endpackage

// File: rtl/can_flt_ram.sv
module can_flt_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    localparam int RAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(waddr) < DEPTH))
            mem[waddr[RAW-1:0]] <= wdata;
    end

    assign rdata = (32'(raddr) < DEPTH) ? mem[raddr[RAW-1:0]] : 32'd0;
endmodule

// File: rtl/can_flt_eval.sv
module can_flt_eval
    import can_flt_pkg::*;
(
    input  logic        is_ext,
    input  logic [31:0] w_a,
    input  logic [31:0] w_b,
    input  logic [28:0] id,
    input  logic [28:0] gmask,
    output elem_res_t   res
);
    logic unused_bit;
    assign unused_bit = w_b[29];

    always_comb begin
        if (!is_ext) begin
            res.code    = w_a[29:27];
            res.hit     = (w_a[29:27] != C_OFF) &&
                          std_match(w_a[31:30], w_a[29:27], id[10:0], w_a[26:16], w_a[10:0]);
            res.buf_idx = w_a[5:0];
            res.dbg_sel = w_a[10:9];
        end else begin
            res.code    = w_a[31:29];
            res.hit     = (w_a[31:29] != C_OFF) &&
                          ext_match(w_b[31:30], w_a[31:29], id, id & gmask,
                                    w_a[28:0], w_b[28:0]);
            res.buf_idx = w_b[5:0];
            res.dbg_sel = w_b[10:9];
        end
    end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_flt_pkg::*;
#(
    parameter int STD_NUM = 16,
    parameter int EXT_NUM = 8,
    localparam int AW  = $clog2((STD_NUM > 2*EXT_NUM) ? STD_NUM : 2*EXT_NUM),
    localparam int SCW = $clog2(STD_NUM + 1),
    localparam int ECW = $clog2(EXT_NUM + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flt_we,
    input  logic           flt_we_ext,
    input  logic [AW-1:0]  flt_waddr,
    input  logic [31:0]    flt_wdata,
    input  logic [SCW-1:0] std_count,
    input  logic [ECW-1:0] ext_count,
    input  logic           std_rtr_reject,
    input  logic           ext_rtr_reject,
    input  logic           std_nomatch_reject,
    input  logic           ext_nomatch_reject,
    input  logic [28:0]    ext_id_mask,
    input  logic           frm_valid,
    input  logic [28:0]    frm_id,
    input  logic           frm_ext,
    input  logic           frm_rtr,
    output logic           res_done,
    output logic [2:0]     res_verdict,
    output logic [6:0]     res_index,
    output logic           res_nomatch,
    output logic           res_prio,
    output logic [6:0]     res_prio_index,
    output logic [5:0]     res_buf_index,
    output logic [1:0]     res_dbg_kind
);
    localparam int LW = AW + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_STD, ST_EXT_A, ST_EXT_B} state_e;

    state_e          st;
    logic [AW-1:0]   ptr;
    logic [LW-1:0]   lim_q, lim_in, std_lim, ext_lim;
    logic [28:0]     id_q;
    logic            ext_q;
    logic [31:0]     w0_q;
    logic            prio_q;
    logic [AW-1:0]   prio_idx_q;
    logic [31:0]     std_rdata, ext_rdata;
    logic [AW-1:0]   ext_raddr;
    elem_res_t       ev;
    logic            busy, eval_now, last;

    // finish decision
    logic            fin, fnm, pset;
    verdict_e        fv;
    logic [6:0]      fidx;
    logic [5:0]      fbi;
    logic [1:0]      fdk;
    logic            prio_cur;
    logic [AW-1:0]   prio_idx_cur;

    assign std_lim = (32'(std_count) > STD_NUM) ? LW'(STD_NUM) : LW'(std_count);
    assign ext_lim = (32'(ext_count) > EXT_NUM) ? LW'(EXT_NUM) : LW'(ext_count);
    assign lim_in  = frm_ext ? ext_lim : std_lim;

    assign ext_raddr = (ptr << 1) | AW'(st == ST_EXT_B);

    can_flt_ram #(.DEPTH(STD_NUM), .AW(AW)) u_std_ram (
        .clk(clk), .we(flt_we && !flt_we_ext), .waddr(flt_waddr), .wdata(flt_wdata),
        .raddr(ptr), .rdata(std_rdata)
    );

    can_flt_ram #(.DEPTH(2*EXT_NUM), .AW(AW)) u_ext_ram (
        .clk(clk), .we(flt_we && flt_we_ext), .waddr(flt_waddr), .wdata(flt_wdata),
        .raddr(ext_raddr), .rdata(ext_rdata)
    );

    can_flt_eval u_eval (
        .is_ext(ext_q),
        .w_a(ext_q ? w0_q : std_rdata),
        .w_b(ext_rdata),
        .id(id_q),
        .gmask(ext_id_mask),
        .res(ev)
    );

    assign busy     = (st != ST_IDLE);
    assign eval_now = (st == ST_STD) || (st == ST_EXT_B);
    assign last     = (LW'(ptr) + LW'(1)) >= lim_q;
    assign prio_cur     = busy ? prio_q : 1'b0;
    assign prio_idx_cur = busy ? prio_idx_q : '0;

    always_comb begin
        fin = 1'b0; fv = V_REJECT; fidx = '0; fnm = 1'b0;
        fbi = '0; fdk = '0; pset = 1'b0;
        if (st == ST_IDLE) begin
            if (frm_valid) begin
                if (frm_rtr && (frm_ext ? ext_rtr_reject : std_rtr_reject)) begin
                    fin = 1'b1;
                end else if (lim_in == '0) begin
                    fin = 1'b1;
                    if (!(frm_ext ? ext_nomatch_reject : std_nomatch_reject)) begin
                        fv = V_FIFO0; fnm = 1'b1;
                    end
                end
            end
        end else if (eval_now) begin
            if (ev.hit) begin
                case (ev.code)
                    C_FIFO0:  begin fin = 1'b1; fv = V_FIFO0; end
                    C_FIFO1:  begin fin = 1'b1; fv = V_FIFO1; end
                    C_REJ:    fin = 1'b1;
                    C_PRIO:   pset = 1'b1;
                    C_PRIO0:  begin pset = 1'b1; fin = 1'b1; fv = V_FIFO0; end
                    C_PRIO1:  begin pset = 1'b1; fin = 1'b1; fv = V_FIFO1; end
                    C_SPECIAL: begin
                        fin = 1'b1;
                        if (ev.dbg_sel == 2'd0) begin
                            fv = V_DBUF; fbi = ev.buf_idx;
                        end else begin
                            fv = V_DEBUG; fdk = ev.dbg_sel;
                        end
                    end
                    default: ;
                endcase
                if (fin) fidx = IDX_W'(ptr);
            end
            if (!fin && last) begin
                fin = 1'b1;
                if (!(ext_q ? ext_nomatch_reject : std_nomatch_reject)) begin
                    fv = V_FIFO0; fnm = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= ST_IDLE;
            ptr            <= '0;
            lim_q          <= '0;
            id_q           <= '0;
            ext_q          <= 1'b0;
            w0_q           <= '0;
            prio_q         <= 1'b0;
            prio_idx_q     <= '0;
            res_done       <= 1'b0;
            res_verdict    <= '0;
            res_index      <= '0;
            res_nomatch    <= 1'b0;
            res_prio       <= 1'b0;
            res_prio_index <= '0;
            res_buf_index  <= '0;
            res_dbg_kind   <= '0;
        end else begin
            res_done <= fin;
            if (fin) begin
                res_verdict    <= fv;
                res_index      <= fidx;
                res_nomatch    <= fnm;
                res_buf_index  <= fbi;
                res_dbg_kind   <= fdk;
                res_prio       <= pset | prio_cur;
                res_prio_index <= IDX_W'(pset ? ptr : prio_idx_cur);
            end
            if (pset) begin
                prio_q     <= 1'b1;
                prio_idx_q <= ptr;
            end
            case (st)
                ST_IDLE: if (frm_valid) begin
                    id_q       <= frm_id;
                    ext_q      <= frm_ext;
                    lim_q      <= lim_in;
                    ptr        <= '0;
                    prio_q     <= 1'b0;
                    prio_idx_q <= '0;
                    if (!fin) st <= frm_ext ? ST_EXT_A : ST_STD;
                end
                ST_STD: begin
                    if (fin) st <= ST_IDLE;
                    else     ptr <= ptr + 1'b1;
                end
                ST_EXT_A: begin
                    w0_q <= ext_rdata;
                    st   <= ST_EXT_B;
                end
                default: begin
                    if (fin) st <= ST_IDLE;
                    else begin
                        ptr <= ptr + 1'b1;
                        st  <= ST_EXT_A;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk
    import can_flt_pkg::*;
#(
    parameter int STD_NUM = 16,
    parameter int EXT_NUM = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       frm_valid,
    input logic       frm_ext,
    input logic       frm_rtr,
    input logic       std_rtr_reject,
    input logic       ext_rtr_reject,
    input logic       res_done,
    input logic [2:0] res_verdict,
    input logic [6:0] res_index,
    input logic       res_nomatch,
    input logic [5:0] res_buf_index,
    input logic [1:0] res_dbg_kind
);
    localparam int MAXN  = (STD_NUM > EXT_NUM) ? STD_NUM : EXT_NUM;
    localparam int BOUND = (STD_NUM > 2*EXT_NUM) ? STD_NUM : 2*EXT_NUM;

    int run_cnt;
    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    assert_nomatch_fifo0_R12: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_nomatch) |-> (res_verdict == 3'(V_FIFO0)));

    assert_dbg_kind_R8: assert property (@(posedge clk) disable iff (rst)
        res_done |-> ((res_verdict == 3'(V_DEBUG)) == (res_dbg_kind != 2'd0)));

    assert_buf_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_verdict != 3'(V_DBUF)) |-> (res_buf_index == 6'd0));

    assert_rtr_reject_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && frm_valid && frm_rtr && (frm_ext ? ext_rtr_reject : std_rtr_reject))
        |=> (res_done && res_verdict == 3'(V_REJECT) && res_index == 7'd0));

    assert_scan_bound_R13: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= BOUND);

    assert_idle_at_done_R13: assert property (@(posedge clk) disable iff (rst)
        res_done |-> !busy);

    assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
        res_done |-> (32'(res_index) < MAXN));
endmodule

bind can_id_filter can_flt_chk #(.STD_NUM(STD_NUM), .EXT_NUM(EXT_NUM)) u_chk (
    .clk(clk), .rst(rst), .busy(busy),
    .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .std_rtr_reject(std_rtr_reject), .ext_rtr_reject(ext_rtr_reject),
    .res_done(res_done), .res_verdict(res_verdict), .res_index(res_index),
    .res_nomatch(res_nomatch), .res_buf_index(res_buf_index),
    .res_dbg_kind(res_dbg_kind)
);

// File: tb/sim_can_id_filter.sv
module sim_can_id_filter;
    localparam int VR = 0, VF0 = 1, VF1 = 2, VB = 3, VD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flt_we = 1'b0, flt_we_ext = 1'b0;
    logic [3:0]  flt_waddr = '0;
    logic [31:0] flt_wdata = '0;
    logic [4:0]  std_count = '0;
    logic [3:0]  ext_count = '0;
    logic        std_rtr_reject = 1'b0, ext_rtr_reject = 1'b0;
    logic        std_nomatch_reject = 1'b0, ext_nomatch_reject = 1'b0;
    logic [28:0] ext_id_mask = 29'h1FFFFFFF;
    logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic        res_done, res_nomatch, res_prio;
    logic [2:0]  res_verdict;
    logic [6:0]  res_index, res_prio_index;
    logic [5:0]  res_buf_index;
    logic [1:0]  res_dbg_kind;

    always #4 clk = ~clk;

    can_id_filter u0 (.*);

    typedef struct {
        int v; int idx; int nm; int ph; int pi; int bi; int dk; int lat; int t0; string req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop and compare whenever a result strobe is seen
    always @(negedge clk) begin
        if (!rst && res_done) begin
            if (sbq.size() == 0) begin
                total++; bad++;
                $display("FAIL R13: unexpected done, got 1 expected 0");
            end else begin
                exp_t e;
                int lat;
                e = sbq.pop_front();
                lat = cyc - e.t0 - 1;
                total++;
                if (int'(res_verdict) != e.v || int'(res_index) != e.idx ||
                    int'(res_nomatch) != e.nm || int'(res_prio) != e.ph ||
                    int'(res_prio_index) != e.pi || int'(res_buf_index) != e.bi ||
                    int'(res_dbg_kind) != e.dk) begin
                    bad++;
                    $display("FAIL %s: got v=%0d i=%0d nm=%0d p=%0d/%0d b=%0d d=%0d exp v=%0d i=%0d nm=%0d p=%0d/%0d b=%0d d=%0d",
                        e.req, res_verdict, res_index, res_nomatch, res_prio, res_prio_index,
                        res_buf_index, res_dbg_kind, e.v, e.idx, e.nm, e.ph, e.pi, e.bi, e.dk);
                end
                total++;
                if (lat != e.lat) begin
                    bad++;
                    $display("FAIL R13 (%s): latency got %0d expected %0d", e.req, lat, e.lat);
                end
            end
        end
    end

    function automatic logic [31:0] mk_s(int typ, int code, int id1, int id2);
        return {2'(typ), 3'(code), 11'(id1), 5'd0, 11'(id2)};
    endfunction
    function automatic logic [31:0] mk_s7(int id1, int act, int bi);
        return {2'd0, 3'd7, 11'(id1), 5'd0, 2'(act), 3'd0, 6'(bi)};
    endfunction
    function automatic logic [31:0] mk_e0(int code, int id1);
        return {3'(code), 29'(id1)};
    endfunction
    function automatic logic [31:0] mk_e1(int typ, int id2);
        return {2'(typ), 1'b0, 29'(id2)};
    endfunction

    task automatic wr(input logic ext, input int addr, input logic [31:0] d);
        @(negedge clk);
        flt_we = 1'b1; flt_we_ext = ext; flt_waddr = 4'(addr); flt_wdata = d;
        @(negedge clk);
        flt_we = 1'b0;
    endtask

    // driver: push the expectation, launch the frame, wait for the monitor
    task automatic run(input int id, input logic ex, input logic rt, input int v, input int idx,
                       input int nm, input int pi, input int bi, input int dk, input int lat,
                       input string req);
        exp_t e;
        @(negedge clk);
        e.v = v; e.idx = idx; e.nm = nm; e.ph = (pi >= 0) ? 1 : 0; e.pi = (pi >= 0) ? pi : 0;
        e.bi = bi; e.dk = dk; e.lat = lat; e.t0 = cyc; e.req = req;
        sbq.push_back(e);
        frm_id = 29'(id); frm_ext = ex; frm_rtr = rt; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R13: watchdog expired, got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (res_done || res_verdict != 0 || res_index != 0 || res_nomatch || res_prio ||
            res_prio_index != 0 || res_buf_index != 0 || res_dbg_kind != 0) begin
            bad++;
            $display("FAIL R1: reset outputs got done=%0d v=%0d i=%0d expected all 0",
                     res_done, res_verdict, res_index);
        end

        // standard list
        wr(0, 0, mk_s(2, 0, 0, 0));           // disabled, would hit everything
        wr(0, 1, mk_s(0, 1, 'h100, 'h10F));
        wr(0, 2, mk_s(1, 2, 'h200, 'h2A5));
        wr(0, 3, mk_s(2, 3, 'h300, 'h7F0));
        wr(0, 4, mk_s(1, 4, 'h400, 'h401));
        wr(0, 5, mk_s(0, 5, 'h402, 'h40F));
        wr(0, 6, mk_s(2, 6, 'h500, 'h7FF));
        wr(0, 7, mk_s7('h600, 0, 'h2A));
        wr(0, 8, mk_s7('h601, 2, 'h11));
        wr(0, 9, mk_s(0, 2, 'h100, 'h1FF));
        // extended list
        wr(1, 0, mk_e0(1, 'h1000000));  wr(1, 1, mk_e1(0, 'h1000FFF));
        wr(1, 2, mk_e0(2, 'h12345670)); wr(1, 3, mk_e1(3, 'h1234567F));
        wr(1, 4, mk_e0(1, 'h0ABCDE00)); wr(1, 5, mk_e1(2, 'h1FFFFF00));
        wr(1, 6, mk_e0(7, 'h77));       wr(1, 7, {3'd0, 18'd0, 2'd3, 3'd0, 6'd0});
        std_count = 5'd10; ext_count = 4'd4;

        run('h105, 0, 0, VF0, 1, 0, -1, 0, 0, 2, "R6 disabled skip");
        run('h100, 0, 0, VF0, 1, 0, -1, 0, 0, 2, "R2 range low");
        run('h10F, 0, 0, VF0, 1, 0, -1, 0, 0, 2, "R2 range high");
        run('h110, 0, 0, VF1, 9, 0, -1, 0, 0, 10, "R6 first hit order");
        run('h1FFFF105, 0, 0, VF0, 1, 0, -1, 0, 0, 2, "R2 low bits only");
        run('h2A5, 0, 0, VF1, 2, 0, -1, 0, 0, 3, "R3 dual");
        run('h200, 0, 0, VF1, 2, 0, -1, 0, 0, 3, "R3 dual first");
        run('h2A4, 0, 0, VF0, 0, 1, -1, 0, 0, 10, "R12 nomatch accept");
        run('h30C, 0, 0, VR, 3, 0, -1, 0, 0, 4, "R4 classic R5 reject");
        run('h31C, 0, 0, VF0, 0, 1, -1, 0, 0, 10, "R4 classic miss");
        run('h401, 0, 0, VF0, 0, 1, 4, 0, 0, 10, "R7 prio continue");
        run('h403, 0, 0, VF0, 5, 0, 5, 0, 0, 6, "R7 prio fifo0");
        run('h500, 0, 0, VF1, 6, 0, 6, 0, 0, 7, "R7 prio fifo1");
        run('h600, 0, 0, VB, 7, 0, -1, 'h2A, 0, 8, "R8 dedicated buffer");
        run('h601, 0, 0, VD, 8, 0, -1, 0, 2, 9, "R8 debug B");
        run('h602, 0, 0, VF0, 0, 1, -1, 0, 0, 10, "R8 exact only");
        run('h105, 0, 1, VF0, 1, 0, -1, 0, 0, 2, "R11 remote kept");
        std_rtr_reject = 1'b1;
        run('h105, 0, 1, VR, 0, 0, -1, 0, 0, 0, "R11 remote std reject");
        run('h1000800, 1, 1, VF0, 0, 0, -1, 0, 0, 2, "R11 ext remote kept");
        ext_rtr_reject = 1'b1;
        run('h1000800, 1, 1, VR, 0, 0, -1, 0, 0, 0, "R11 remote ext reject");
        std_nomatch_reject = 1'b1;
        run('h7FF, 0, 0, VR, 0, 0, -1, 0, 0, 10, "R12 nomatch reject");
        run('h1FFFFFFF, 1, 0, VF0, 0, 1, -1, 0, 0, 8, "R12 ext separate");
        ext_nomatch_reject = 1'b1;
        run('h1FFFFFFF, 1, 0, VR, 0, 0, -1, 0, 0, 8, "R12 ext reject");
        ext_nomatch_reject = 1'b0;

        // extended list and mask
        run('h1000800, 1, 0, VF0, 0, 0, -1, 0, 0, 2, "R9 ext range");
        run('h12345678, 1, 0, VF1, 1, 0, -1, 0, 0, 4, "R10 raw range");
        run('h11000800, 1, 0, VF0, 0, 1, -1, 0, 0, 8, "R9 full mask miss");
        run('h77, 1, 0, VD, 3, 0, -1, 0, 3, 8, "R8 ext debug C");
        ext_id_mask = 29'h0FFFFFFF;
        run('h11000800, 1, 0, VF0, 0, 0, -1, 0, 0, 2, "R9 mask range");
        run('h1ABCDE55, 1, 0, VF0, 2, 0, -1, 0, 0, 6, "R9 mask classic");
        run('h12345678, 1, 0, VF1, 1, 0, -1, 0, 0, 4, "R10 bypass mask");
        ext_id_mask = 29'h1FFFFFFF;

        // list length
        std_nomatch_reject = 1'b0;
        std_count = 5'd1;
        run('h105, 0, 0, VF0, 0, 1, -1, 0, 0, 1, "R14 short list");
        std_count = 5'd0;
        run('h105, 0, 0, VF0, 0, 1, -1, 0, 0, 0, "R14 empty list");
        ext_count = 4'd1;
        run('h12345678, 1, 0, VF0, 0, 1, -1, 0, 0, 2, "R14 ext short list");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule